// File: doc/BRIEF.md
# Polled Serial Meter Station

This block is a remote acquisition station on an asynchronous serial line. It stays silent until the host sends a one-byte poll. If that byte equals the station's strapped address, the station replies with the reading of a four-digit decimal meter. A byte with any other value is dropped, so several stations can share one host line.

The reply takes one of two forms. In the packed decimal form, two bytes each carry two digits. In the character form, each of the four digits goes out as one byte. In continuous mode the station does not send the live reading. It captures a reading into an on-chip first-in-first-out store each time `sample_stb` pulses. The next matching poll then drains everything captured, oldest first.

Receive and transmit each have a holding register behind the shift register. A poll that arrives while a reply is going out is kept and answered afterwards, and the sequencer can queue the next reply byte while the current one is on the line.

Top module: `polled_meter_node`

## Requirements
- R1: Every character on `rxd` and `txd` has one low start bit, eight data bits sent least significant bit first and one high stop bit. The line rests high. One bit lasts 16 ticks of the rate divider.
- R2: `rate_sel` picks the bit rate: 0 selects 110 bit/s, 1 selects 2400 bit/s, and 2 or 3 select 4800 bit/s. The divider is derived from the `CLK_HZ` parameter.
- R3: With `cont_mode`=0 and `fmt_ascii`=0, a poll equal to `station_code` is answered with two bytes: `reading[15:8]` first, then `reading[7:0]`. The digit in bits 15:12 is the most significant.
- R4: With `fmt_ascii`=1, a matching poll is answered with four bytes, most significant digit first. Each byte is 0xB0 plus the digit value.
- R5: A received byte that differs from `station_code` is discarded and produces no activity on `txd`.
- R6: A frame whose stop bit samples low is discarded, even if its data matches, and `frame_err` goes high. `frame_err` returns low on the next well-framed byte.
- R7: In character form, a digit from 0xA to 0xF goes out as 0x3F. `bad_digit` is updated at every matching live poll: it is 1 if any digit of the reading was out of range, and 0 otherwise.
- R8: Two matching polls sent back to back both receive a complete reply, one after the other.
- R9: With `cont_mode`=1, each `sample_stb` pulse stores two bytes, `reading[15:8]` then `reading[7:0]`. A matching poll then sends every stored byte in arrival order until the store is empty. An empty store sends nothing.
- R10: A sample is dropped when fewer than two byte slots are free. `fifo_ovf` then goes high and stays high until the next matching poll in continuous mode.
- R11: After reset, `txd` is 1, `tx_empty` is 1, and `rx_full`, `frame_err`, `bad_digit` and `fifo_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line from the host |
| rate_sel | input | 2 | Bit rate select |
| station_code | input | 8 | Preset address this station answers to |
| fmt_ascii | input | 1 | 1: character reply, 0: packed decimal reply |
| cont_mode | input | 1 | 1: capture samples and drain them on a poll |
| reading | input | 16 | Four decimal digits from the meter |
| sample_stb | input | 1 | One-cycle capture request in continuous mode |
| txd | output | 1 | Serial line to the host |
| rx_full | output | 1 | Receive holding register occupied |
| tx_empty | output | 1 | Transmit holding register free |
| frame_err | output | 1 | Last frame had a low stop bit |
| bad_digit | output | 1 | Last live reading had a non-decimal digit |
| fifo_ovf | output | 1 | A sample was lost to a full store |

## Verification
The bench targets the places where a station would most easily misbehave:
- **Low stop bit.** A poll whose stop bit is low carries the matching address. A receiver that ignored the stop bit would answer it.
- **Back-to-back polls.** A second poll lands while the first reply is still on the line. Without a receive holding register, the second poll would be lost or would cut the first reply short.
- **Store overflow.** The store is filled past capacity. A wrong free-slot test would either lose data early or wrap over the oldest entries; either way the drained byte count or the last pair would be wrong.
- **Bad digit and rate change.** An out-of-range digit is sent, and the bit rate is switched. Missing digit substitution, or a divider tied to the wrong rate, shows up as garbled reply bytes.

// File: rtl/polled_meter_node.sv
module polled_meter_node #(
  parameter int CLK_HZ = 1_000_000,
  parameter int DEPTH  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd,
  input  logic [1:0]  rate_sel,
  input  logic [7:0]  station_code,
  input  logic        fmt_ascii,
  input  logic        cont_mode,
  input  logic [15:0] reading,
  input  logic        sample_stb,
  output logic        txd,
  output logic        rx_full,
  output logic        tx_empty,
  output logic        frame_err,
  output logic        bad_digit,
  output logic        fifo_ovf
);
  localparam int DIV_LO  = CLK_HZ / (16 * 110);
  localparam int DIV_MID = CLK_HZ / (16 * 2400);
  localparam int DIV_HI  = CLK_HZ / (16 * 4800);
  localparam int DW = $clog2(DIV_LO + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LIM  = (AW+1)'(DEPTH - 2);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  // rate divider
  logic [DW-1:0] div_cnt, div_sel;
  logic tick;
  always_comb
    case (rate_sel)
      2'd0:    div_sel = DW'(DIV_LO);
      2'd1:    div_sel = DW'(DIV_MID);
      default: div_sel = DW'(DIV_HI);
    endcase
  assign tick = div_cnt >= div_sel - DW'(1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + DW'(1);

  // receiver
  logic [1:0] rsync;
  logic       rx_act;
  logic [3:0] rx_tk, rx_bit;
  logic [7:0] rx_sh, rx_hold;
  logic       busy, consume;
  wire        rx_s = rsync[1];
  assign consume = rx_full && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsync <= 2'b11; rx_act <= 1'b0; rx_tk <= '0; rx_bit <= '0;
      rx_sh <= '0; rx_hold <= '0; rx_full <= 1'b0; frame_err <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (consume) rx_full <= 1'b0;
      if (tick) begin
        if (!rx_act) begin
          if (!rx_s) begin rx_act <= 1'b1; rx_tk <= '0; rx_bit <= '0; end
        end else begin
          rx_tk <= rx_tk + 4'd1;
          if (rx_tk == 4'd7) begin
            rx_bit <= rx_bit + 4'd1;
            if (rx_bit == 4'd0) begin
              if (rx_s) rx_act <= 1'b0;
            end else if (rx_bit == 4'd9) begin
              rx_act <= 1'b0;
              if (rx_s) begin
                frame_err <= 1'b0;
                if (!rx_full) begin rx_hold <= rx_sh; rx_full <= 1'b1; end
              end else frame_err <= 1'b1;
            end else rx_sh <= {rx_s, rx_sh[7:1]};
          end
        end
      end
    end

  // sample store
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, drop, pop;
  assign push = cont_mode && sample_stb && (cnt <= LIM);
  assign drop = cont_mode && sample_stb && !(cnt <= LIM);

  always_ff @(posedge clk)
    if (push) begin
      mem[wp]          <= reading[15:8];
      mem[wp + AW'(1)] <= reading[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin wp <= '0; rp <= '0; cnt <= '0; end
    else begin
      if (push) wp <= wp + AW'(2);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'({push, 1'b0}) - (AW+1)'(pop);
    end

  // reply sequencer and transmit holding register
  logic        dump, asc, hold_v, tx_busy, tx_load, feed, last;
  logic [1:0]  idx;
  logic [15:0] snap;
  logic [7:0]  hold, nxt;
  logic [3:0]  dg;
  wire         match = consume && (rx_hold == station_code);
  wire         any_bad = (reading[15:12] > 4'd9) || (reading[11:8] > 4'd9) ||
                         (reading[7:4] > 4'd9)   || (reading[3:0] > 4'd9);

  assign dg   = snap[4*(3-idx) +: 4];
  assign nxt  = asc ? ((dg > 4'd9) ? 8'h3F : {4'hB, dg})
                    : (idx[0] ? snap[7:0] : snap[15:8]);
  assign last = asc ? (idx == 2'd3) : (idx == 2'd1);
  assign feed = busy && !hold_v;
  assign pop  = feed && dump && (cnt != '0);
  assign tx_load  = hold_v && !tx_busy;
  assign tx_empty = !hold_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; dump <= 1'b0; asc <= 1'b0; idx <= '0; snap <= '0;
      hold <= '0; hold_v <= 1'b0; bad_digit <= 1'b0; fifo_ovf <= 1'b0;
    end else begin
      if (match) begin
        busy <= 1'b1; dump <= cont_mode; asc <= fmt_ascii; idx <= '0; snap <= reading;
        if (cont_mode) fifo_ovf <= 1'b0;
        else           bad_digit <= any_bad;
      end
      if (drop) fifo_ovf <= 1'b1;
      if (tx_load) hold_v <= 1'b0;
      if (feed) begin
        if (dump) begin
          if (cnt != '0) begin hold <= mem[rp]; hold_v <= 1'b1; end
          else busy <= 1'b0;
        end else begin
          hold <= nxt; hold_v <= 1'b1; idx <= idx + 2'd1;
          if (last) busy <= 1'b0;
        end
      end
    end

  // transmitter
  logic [9:0] tx_sh;
  logic [3:0] tx_tk, tx_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin tx_busy <= 1'b0; tx_sh <= '1; tx_tk <= '0; tx_n <= '0; end
    else if (tx_load) begin
      tx_sh <= {1'b1, hold, 1'b0}; tx_busy <= 1'b1; tx_tk <= '0; tx_n <= '0;
    end else if (tx_busy && tick) begin
      tx_tk <= tx_tk + 4'd1;
      if (tx_tk == 4'd15) begin
        tx_sh <= {1'b1, tx_sh[9:1]};
        tx_n  <= tx_n + 4'd1;
        if (tx_n == 4'd9) tx_busy <= 1'b0;
      end
    end
  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  a_r5_mismatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && rx_hold != station_code) |=> !busy);
  a_r6_bad_stop_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !$rose(rx_full));
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && tx_busy) |=> (hold_v && $stable(hold)));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r10_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_ovf) |-> ($past(cnt) > LIM));
endmodule

// File: tb/polled_meter_node_tb.sv
module polled_meter_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 153600;
  localparam int D_LO = 87, D_MID = 4, D_HI = 2;
  localparam logic [7:0] CODE = 8'h5A;

  logic clk = 0, rst_n = 0, rxd = 1, fmt_ascii = 0, cont_mode = 0, sample_stb = 0;
  logic [1:0] rate_sel = 2'd2;
  logic [7:0] station_code = CODE;
  logic [15:0] reading = 16'h0;
  logic txd, rx_full, tx_empty, frame_err, bad_digit, fifo_ovf;
  int checks = 0, errors = 0;
  logic [7:0] got [0:63];
  int got_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  polled_meter_node #(.CLK_HZ(CLK_HZ), .DEPTH(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rate_sel(rate_sel),
    .station_code(station_code), .fmt_ascii(fmt_ascii), .cont_mode(cont_mode),
    .reading(reading), .sample_stb(sample_stb), .txd(txd), .rx_full(rx_full),
    .tx_empty(tx_empty), .frame_err(frame_err), .bad_digit(bad_digit), .fifo_ovf(fifo_ovf));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic send_byte(input logic [7:0] b, input int div, input bit stop_v);
    int bc = 16 * div;
    rxd = 0; repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bc) @(negedge clk); end
    rxd = stop_v; repeat (bc) @(negedge clk);
    rxd = 1; repeat (bc) @(negedge clk);
  endtask

  task automatic collect(input int n, input int div);
    int bc = 16 * div;
    got_n = 0;
    for (int k = 0; k < n; k++) begin
      int w = 0;
      logic [7:0] b;
      while (txd && w < 40 * bc) begin @(negedge clk); w++; end
      if (txd) return;
      repeat (bc / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (bc) @(negedge clk); b[i] = txd; end
      repeat (bc) @(negedge clk);
      chk(txd == 1'b1, "R1 stop bit", 32'(txd), 1);
      got[k] = b; got_n++;
    end
  endtask

  task automatic poll(input logic [7:0] c, input int div, input int n, input bit stop_v);
    fork
      send_byte(c, div, stop_v);
      collect(n, div);
    join
  endtask

  task automatic t_reset;
    chk(txd == 1 && tx_empty == 1, "R11 idle tx", {txd, tx_empty}, 2'b11);
    chk({rx_full, frame_err, bad_digit, fifo_ovf} == 4'b0, "R11 flags", {rx_full, frame_err, bad_digit, fifo_ovf}, 0);
  endtask

  task automatic t_bcd;
    reading = 16'h1234; fmt_ascii = 0;
    poll(CODE, D_HI, 2, 1);
    chk(got_n == 2, "R3 byte count", got_n, 2);
    chk(got[0] == 8'h12 && got[1] == 8'h34, "R3 R1 packed bytes", {got[0], got[1]}, 16'h1234);
  endtask

  task automatic t_bad_digit;
    reading = 16'h12A4; fmt_ascii = 1;
    poll(CODE, D_HI, 4, 1);
    chk(got_n == 4, "R7 count", got_n, 4);
    chk({got[0], got[1], got[2], got[3]} == 32'hB1B23FB4, "R7 substitution",
        {got[0], got[1], got[2], got[3]}, 32'hB1B23FB4);
    chk(bad_digit == 1, "R7 flag set", bad_digit, 1);
  endtask

  task automatic t_ascii;
    reading = 16'h9078; fmt_ascii = 1;
    poll(CODE, D_HI, 4, 1);
    chk({got[0], got[1], got[2], got[3]} == 32'hB9B0B7B8, "R4 character digits",
        {got[0], got[1], got[2], got[3]}, 32'hB9B0B7B8);
    chk(bad_digit == 0, "R7 flag cleared", bad_digit, 0);
    fmt_ascii = 0;
  endtask

  task automatic t_mismatch;
    poll(8'hA5, D_HI, 1, 1);
    chk(got_n == 0, "R5 no reply", got_n, 0);
  endtask

  task automatic t_frame;
    reading = 16'h4321;
    poll(CODE, D_HI, 1, 0);
    chk(got_n == 0, "R6 dropped frame", got_n, 0);
    chk(frame_err == 1, "R6 flag set", frame_err, 1);
    poll(CODE, D_HI, 2, 1);
    chk(got_n == 2 && got[0] == 8'h43 && got[1] == 8'h21, "R6 recovery", {got[0], got[1]}, 16'h4321);
    chk(frame_err == 0, "R6 flag cleared", frame_err, 0);
  endtask

  task automatic t_b2b;
    reading = 16'h5678;
    fork
      begin send_byte(CODE, D_HI, 1); send_byte(CODE, D_HI, 1); end
      collect(4, D_HI);
    join
    chk(got_n == 4, "R8 both answered", got_n, 4);
    chk({got[0], got[1], got[2], got[3]} == 32'h56785678, "R8 reply order",
        {got[0], got[1], got[2], got[3]}, 32'h56785678);
  endtask

  task automatic t_rate;
    reading = 16'h0917;
    rate_sel = 2'd1; poll(CODE, D_MID, 2, 1);
    chk(got_n == 2 && got[0] == 8'h09 && got[1] == 8'h17, "R2 2400", {got[0], got[1]}, 16'h0917);
    rate_sel = 2'd0; poll(CODE, D_LO, 2, 1);
    chk(got_n == 2 && got[0] == 8'h09 && got[1] == 8'h17, "R2 110", {got[0], got[1]}, 16'h0917);
    rate_sel = 2'd2;
  endtask

  task automatic pulse(input logic [15:0] v);
    reading = v; sample_stb = 1; @(negedge clk); sample_stb = 0; @(negedge clk);
  endtask

  task automatic t_fifo;
    cont_mode = 1;
    pulse(16'h1234); pulse(16'h5678); pulse(16'h9ABC);
    reading = 16'h0000;
    poll(CODE, D_HI, 6, 1);
    chk(got_n == 6, "R9 count", got_n, 6);
    chk({got[0], got[1], got[2], got[3], got[4], got[5]} == 48'h123456789ABC, "R9 order",
        {got[2], got[3], got[4], got[5]}, 32'h56789ABC);
    poll(CODE, D_HI, 1, 1);
    chk(got_n == 0, "R9 empty store silent", got_n, 0);
  endtask

  task automatic t_ovf;
    for (int k = 0; k < 33; k++) pulse({8'(k), ~8'(k)});
    chk(fifo_ovf == 1, "R10 flag set", fifo_ovf, 1);
    poll(CODE, D_HI, 64, 1);
    chk(got_n == 64, "R10 kept count", got_n, 64);
    chk(got[0] == 8'h00 && got[1] == 8'hFF, "R10 first pair", {got[0], got[1]}, 16'h00FF);
    chk(got[62] == 8'd31 && got[63] == ~8'd31, "R10 last pair", {got[62], got[63]}, {8'd31, ~8'd31});
    chk(fifo_ovf == 0, "R10 flag cleared", fifo_ovf, 0);
    cont_mode = 0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bcd();
    t_bad_digit();
    t_ascii();
    t_mismatch();
    t_frame();
    t_b2b();
    t_rate();
    t_fifo();
    t_ovf();
    finish_run();
  end
endmodule